// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns an operand reference into a linear address. The reference is an optional base register, an optional index register with a scale code, and a displacement. The sum of these is the offset. A segment contribution is then added to the offset. It can work in two ways.

In real mode the 16-bit segment value is shifted left by four and added to the low 16 bits of the offset. The 21-bit sum, including its carry, is the linear address, and no protection check is made. In protected mode a cached 32-bit descriptor base is added to the full 32-bit offset. The offset is also compared against the descriptor limit, which is 20 bits wide and counts either in bytes or in 4 KB pages.

Requests enter on a valid/ready stream, and results leave on another. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. The result is registered and is offered on the next cycle. While the output holds a result that the consumer has not taken (`out_valid` high and `out_ready` low), `in_ready` is low, and the output payload holds steady until the consumer takes it. When the consumer takes the result on the same edge, a new request can be accepted on that edge, so the block sustains one result per cycle.

Top module: `seg_agu`

## Requirements
- R1: The scale code multiplies the index: code 0 gives x1, 1 gives x2, 2 gives x4, and 3 gives x8.
- R2: When a register's valid flag is low, that register adds zero to the offset. When the valid flag is high, its value is added.
- R3: In real mode (`in_prot` = 0), `out_lin` is ({`in_seg`, 4'b0} + offset[15:0]). This is a 21-bit sum including its carry, and `out_lin[31:21]` is zero.
- R4: In real mode, `out_limit_fault` is always 0.
- R5: In protected mode (`in_prot` = 1), the offset is base + index*scale + displacement modulo 2^32, and `out_lin` is `in_desc_base` + offset modulo 2^32.
- R6: In protected mode with `in_desc_gran` = 0, the effective limit is `in_desc_limit`, counted in bytes. `out_limit_fault` is 1 exactly when the offset is greater than the effective limit. An offset equal to the limit does not fault.
- R7: In protected mode with `in_desc_gran` = 1, the effective limit is {`in_desc_limit`, 12'hFFF}. The fault is judged as in R6, and the address is still produced when a fault is flagged.
- R8: A request accepted on one edge appears on `out_valid`/`out_lin`/`out_limit_fault` after that edge. While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and the output payload is stable. `in_ready` = !`out_valid` || `out_ready`.
- R9: While `rst_n` is low and after reset, `out_valid` is 0 and `out_lin` and `out_limit_fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request |
| in_prot | input | 1 | 1 = protected mode, 0 = real mode |
| in_base | input | 32 | Base register value |
| in_base_vld | input | 1 | Base register is used |
| in_index | input | 32 | Index register value |
| in_index_vld | input | 1 | Index register is used |
| in_scale | input | 2 | Scale code (x1, x2, x4, x8) |
| in_disp | input | 32 | Displacement |
| in_seg | input | 16 | Real-mode segment value |
| in_desc_base | input | 32 | Protected-mode descriptor base |
| in_desc_limit | input | 20 | Protected-mode descriptor limit |
| in_desc_gran | input | 1 | Limit counts in 4 KB pages when 1 |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_lin | output | 32 | Linear address |
| out_limit_fault | output | 1 | Protected-mode offset exceeds the limit |

## Verification
Each result is due on the clock edge after its request is accepted, and it stays on the output until the edge where `out_ready` is high. The bench predicts each address and fault flag from the requirements and queues the prediction when it sees an acceptance. It compares a result only in the cycle before the edge that transfers it. Because `out_ready` follows an irregular pattern, back-pressure is exercised throughout the run. The bench also checks that a held result does not change from one cycle to the next while the consumer stalls.

// File: rtl/seg_agu_pkg.sv
package seg_agu_pkg;
  typedef enum logic {MODE_REAL = 1'b0, MODE_PROT = 1'b1} agu_mode_e;

  // Width of a real-mode sum: shifted segment plus carry.
  function automatic int real_sum_w(input int seg_w, input int seg_shift);
    return seg_w + seg_shift + 1;
  endfunction
endpackage

// File: rtl/agu_offset_calc.sv
module agu_offset_calc #(
  parameter int AW = 32,
  parameter int SCW = 2
) (
  input  logic [AW-1:0]  base,
  input  logic           base_vld,
  input  logic [AW-1:0]  index,
  input  logic           index_vld,
  input  logic [SCW-1:0] scale,
  input  logic [AW-1:0]  disp,
  output logic [AW-1:0]  offset
);
  logic [AW-1:0] base_term;
  logic [AW-1:0] index_term;

  always_comb begin
    base_term  = base_vld  ? base : '0;
    index_term = index_vld ? (index << scale) : '0;
    offset     = base_term + index_term + disp;
  end
endmodule

// File: rtl/agu_limit_check.sv
module agu_limit_check #(
  parameter int AW = 32,
  parameter int LIMW = 20,
  parameter int PG_SHIFT = 12
) (
  input  logic [AW-1:0]   offset,
  input  logic [LIMW-1:0] limit,
  input  logic            gran,
  output logic            fault
);
  localparam int EW = LIMW + PG_SHIFT;
  localparam int CW = (EW > AW) ? EW : AW;

  logic [CW-1:0] eff_limit;
  logic [CW-1:0] off_ext;

  always_comb begin
    if (gran) eff_limit = CW'({limit, {PG_SHIFT{1'b1}}});
    else      eff_limit = CW'(limit);
    off_ext = CW'(offset);
    fault   = off_ext > eff_limit;
  end
endmodule

// File: rtl/agu_linear_sum.sv
module agu_linear_sum
  import seg_agu_pkg::*;
#(
  parameter int AW = 32,
  parameter int SEGW = 16,
  parameter int SEG_SHIFT = 4,
  parameter int ROFFW = 16
) (
  input  agu_mode_e       mode,
  input  logic [SEGW-1:0] seg,
  input  logic [AW-1:0]   desc_base,
  input  logic [AW-1:0]   offset,
  output logic [AW-1:0]   lin
);
  localparam int RW = real_sum_w(SEGW, SEG_SHIFT);

  logic [RW-1:0] real_sum;

  always_comb begin
    real_sum = RW'({seg, {SEG_SHIFT{1'b0}}}) + RW'(offset[ROFFW-1:0]);
    if (mode == MODE_PROT) lin = desc_base + offset;
    else                   lin = AW'(real_sum);
  end
endmodule

// File: rtl/agu_out_stage.sv
module agu_out_stage #(
  parameter int W = 33
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  assign up_ready = !dn_valid || dn_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_data  <= '0;
    end else if (up_ready) begin
      dn_valid <= up_valid;
      if (up_valid) dn_data <= up_data;
    end
  end
endmodule

// File: rtl/seg_agu.sv
module seg_agu
  import seg_agu_pkg::*;
#(
  parameter int AW = 32,
  parameter int SEGW = 16,
  parameter int LIMW = 20,
  parameter int SCW = 2,
  parameter int SEG_SHIFT = 4,
  parameter int ROFFW = 16,
  parameter int PG_SHIFT = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            in_prot,
  input  logic [AW-1:0]   in_base,
  input  logic            in_base_vld,
  input  logic [AW-1:0]   in_index,
  input  logic            in_index_vld,
  input  logic [SCW-1:0]  in_scale,
  input  logic [AW-1:0]   in_disp,
  input  logic [SEGW-1:0] in_seg,
  input  logic [AW-1:0]   in_desc_base,
  input  logic [LIMW-1:0] in_desc_limit,
  input  logic            in_desc_gran,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [AW-1:0]   out_lin,
  output logic            out_limit_fault
);
  localparam int PW = AW + 1;

  agu_mode_e     mode;
  logic [AW-1:0] offset;
  logic [AW-1:0] lin;
  logic          raw_fault;
  logic          fault;
  logic [PW-1:0] pay_in;
  logic [PW-1:0] pay_out;

  assign mode = agu_mode_e'(in_prot);

  agu_offset_calc #(.AW(AW), .SCW(SCW)) u_off (
    .base(in_base), .base_vld(in_base_vld),
    .index(in_index), .index_vld(in_index_vld),
    .scale(in_scale), .disp(in_disp), .offset(offset)
  );

  agu_limit_check #(.AW(AW), .LIMW(LIMW), .PG_SHIFT(PG_SHIFT)) u_lim (
    .offset(offset), .limit(in_desc_limit), .gran(in_desc_gran), .fault(raw_fault)
  );

  agu_linear_sum #(.AW(AW), .SEGW(SEGW), .SEG_SHIFT(SEG_SHIFT), .ROFFW(ROFFW)) u_lin (
    .mode(mode), .seg(in_seg), .desc_base(in_desc_base), .offset(offset), .lin(lin)
  );

  // Real mode carries no protection check.
  assign fault  = (mode == MODE_PROT) && raw_fault;
  assign pay_in = {fault, lin};

  agu_out_stage #(.W(PW)) u_out (
    .clk(clk), .rst_n(rst_n),
    .up_valid(in_valid), .up_ready(in_ready), .up_data(pay_in),
    .dn_valid(out_valid), .dn_ready(out_ready), .dn_data(pay_out)
  );

  assign out_lin         = pay_out[AW-1:0];
  assign out_limit_fault = pay_out[AW];
endmodule

// File: rtl/seg_agu_chk.sv
module seg_agu_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_prot,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] out_lin,
  input logic          out_limit_fault
);
  // R8: a stalled result stays put
  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_lin) && $stable(out_limit_fault)));

  // R8: no acceptance while stalled
  assert_stall_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R8: an accepted request produces a result next cycle
  assert_accept_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R4: real-mode requests never fault
  assert_real_no_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_prot) |=> !out_limit_fault);

  // R3: real-mode address fits in 21 bits
  assert_real_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_prot) |=> (out_lin[AW-1:21] == '0));

  // R9: nothing offered right after reset
  assert_reset_idle_R9: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

bind seg_agu seg_agu_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_prot(in_prot), .out_valid(out_valid), .out_ready(out_ready),
  .out_lin(out_lin), .out_limit_fault(out_limit_fault)
);

// File: tb/seg_agu_test.sv
`timescale 1ns/1ps
module seg_agu_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic        in_prot = 0;
  logic [31:0] in_base = 0;
  logic        in_base_vld = 0;
  logic [31:0] in_index = 0;
  logic        in_index_vld = 0;
  logic [1:0]  in_scale = 0;
  logic [31:0] in_disp = 0;
  logic [15:0] in_seg = 0;
  logic [31:0] in_desc_base = 0;
  logic [19:0] in_desc_limit = 0;
  logic        in_desc_gran = 0;
  logic        out_valid;
  logic        out_ready = 0;
  logic [31:0] out_lin;
  logic        out_limit_fault;

  always #2 clk = ~clk;

  seg_agu uut (.*);

  typedef struct {
    logic [31:0] lin;
    logic        flt;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit run_mon = 0;
  bit stalled = 0;
  logic [31:0] held_lin;
  logic held_flt;

  // Model written from the requirements.
  function automatic exp_t model(bit prot, logic [31:0] b, bit bv, logic [31:0] x, bit xv,
                                 logic [1:0] sc, logic [31:0] d, logic [15:0] sg,
                                 logic [31:0] db, logic [19:0] lim, bit g, string tag);
    exp_t e;
    logic [63:0] off, lim_eff;
    off = (bv ? 64'(b) : 64'd0) + (xv ? 64'(x) * (64'd1 << sc) : 64'd0) + 64'(d);
    off = off & 64'hFFFF_FFFF;
    if (!prot) begin
      e.lin = 32'((64'(sg) * 16 + (off & 64'hFFFF)) & 64'h1F_FFFF);
      e.flt = 0;
    end else begin
      e.lin = 32'((64'(db) + off) & 64'hFFFF_FFFF);
      lim_eff = g ? (64'(lim) * 4096 + 4095) : 64'(lim);
      e.flt = off > lim_eff;
    end
    e.tag = tag;
    return e;
  endfunction

  task automatic send(bit prot, logic [31:0] b, bit bv, logic [31:0] x, bit xv,
                      logic [1:0] sc, logic [31:0] d, logic [15:0] sg,
                      logic [31:0] db, logic [19:0] lim, bit g, string tag);
    @(negedge clk); #1;
    in_prot = prot; in_base = b; in_base_vld = bv; in_index = x; in_index_vld = xv;
    in_scale = sc; in_disp = d; in_seg = sg; in_desc_base = db; in_desc_limit = lim;
    in_desc_gran = g; in_valid = 1;
    while (!in_ready) begin
      @(negedge clk); #1;
    end
    exp_q.push_back(model(prot, b, bv, x, xv, sc, d, sg, db, lim, g, tag));
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  // Monitor: sets out_ready for the coming edge, then checks what that edge transfers.
  always @(negedge clk) begin
    cyc++;
    if (run_mon) begin
      if (stalled) begin
        checks++;
        if (!out_valid || out_lin !== held_lin || out_limit_fault !== held_flt) begin
          errors++;
          $display("FAIL R8 hold: got v=%0b lin=%h f=%0b expected v=1 lin=%h f=%0b",
                   out_valid, out_lin, out_limit_fault, held_lin, held_flt);
        end
      end
      out_ready = !((cyc % 5) == 2 || (cyc % 7) == 3);
      stalled = out_valid && !out_ready;
      held_lin = out_lin;
      held_flt = out_limit_fault;
      if (out_valid && out_ready) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R8 unexpected result lin=%h expected none", out_lin);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (out_lin !== e.lin || out_limit_fault !== e.flt) begin
            errors++;
            $display("FAIL %s: got lin=%h f=%0b expected lin=%h f=%0b",
                     e.tag, out_lin, out_limit_fault, e.lin, e.flt);
          end
        end
      end
    end
  end

  initial begin : watchdog
    #400000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 0 || out_lin !== 0 || out_limit_fault !== 0 || in_ready !== 1) begin
      errors++;
      $display("FAIL R9 reset: got v=%0b lin=%h f=%0b rdy=%0b expected 0 0 0 1",
               out_valid, out_lin, out_limit_fault, in_ready);
    end
    rst_n = 1;
    run_mon = 1;

    for (int s = 0; s < 4; s++)
      send(1, 32'h0, 0, 32'h0000_0013, 1, 2'(s), 32'h10, 16'h0, 32'h0100_0000,
           20'hFFFFF, 1, "R1 scale");
    send(1, 32'h1234, 0, 32'h50, 1, 2'd1, 32'h4, 16'h0, 32'h0, 20'hFFFFF, 1, "R2 base invalid");
    send(1, 32'h1234, 1, 32'h50, 0, 2'd3, 32'h4, 16'h0, 32'h0, 20'hFFFFF, 1, "R2 index invalid");
    send(1, 32'h1234, 1, 32'h50, 1, 2'd2, 32'h0, 16'h0, 32'h0, 20'hFFFFF, 1, "R2 both valid no disp");
    send(0, 32'h0, 0, 32'h0, 0, 2'd0, 32'h0000_FFFF, 16'hFFFF, 32'h0, 20'h0, 0, "R3 real carry");
    send(0, 32'h000F_FFF0, 1, 32'h8, 1, 2'd1, 32'h0, 16'h1000, 32'h0, 20'h0, 0, "R3 real offset wrap");
    send(0, 32'hFFFF_FFFF, 1, 32'hFFFF, 1, 2'd3, 32'h7FFF_0000, 16'h0001, 32'h0, 20'h0, 0,
         "R4 real no fault");
    send(1, 32'hFFFF_FFF0, 1, 32'h20, 1, 2'd0, 32'h0, 16'h0, 32'hF000_0000, 20'hFFFFF, 1,
         "R5 offset wrap");
    send(1, 32'h100, 1, 32'h0, 0, 2'd0, 32'h0, 16'h0, 32'hFFFF_FF80, 20'hFFFFF, 1, "R5 linear wrap");
    send(1, 32'h0, 0, 32'h0, 0, 2'd0, 32'h0000_0FFF, 16'h0, 32'h2000, 20'h00FFF, 0, "R6 at limit");
    send(1, 32'h0, 0, 32'h0, 0, 2'd0, 32'h0000_1000, 16'h0, 32'h2000, 20'h00FFF, 0, "R6 over limit");
    send(1, 32'h0, 0, 32'h0, 0, 2'd0, 32'h0000_1FFF, 16'h0, 32'h4000, 20'h00001, 1, "R7 at page limit");
    send(1, 32'h0, 0, 32'h0, 0, 2'd0, 32'h0000_2000, 16'h0, 32'h4000, 20'h00001, 1, "R7 over page limit");
    send(1, 32'h0, 0, 32'h0, 0, 2'd0, 32'h0000_2000, 16'h0, 32'h4000, 20'h00001, 0, "R6 byte granularity");
    for (int k = 0; k < 20; k++)
      send(k[0], 32'h0001_0000 * k, 1, 32'h333 + k, k[1], 2'(k), 32'h77 * k, 16'(k * 16'h111),
           32'h0010_0000, 20'(k * 20'h10), k[2], "R8 streaming");

    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule